// File: doc/BRIEF.md
# Synchronous Serial Byte Transceiver with Clock-Line Handshake

This block is one synchronous serial channel that moves a byte at a time between a single parallel buffer register and a serial data pin. Static mode inputs select its role. As master it generates the serial clock from the system clock. As slave it follows a clock that arrives from outside. A second mode input makes it either a transmitter or a receiver. A CPU-side port loads and reads the buffer. A done flag reports the end of each byte.

The clock pin is modelled as an open-drain node with an external pull-up. The block drives it only through a pull-low enable and reads it back through a sampled input. The data pin is modelled as separate input, output and output-enable signals. With the handshake mode turned on, the clock polarity is inverted. A slave that cannot take part in the next byte holds the shared clock line low, and the master waits for the line to return high before it starts clocking.

Top module: `sser_chan`

## Requirements
- R1: After reset the done flag is 0, the buffer reads 0x00, the data output enable is 0, and a master does not pull the clock line low.
- R2: A master clocks each byte with exactly 8 low pulses on the clock line. Each low phase and each high phase lasts `cfg_div`+1 system clocks, and `cfg_div` must be at least 3. The master leaves its clock output released (high) at the end of the byte.
- R3: A transmitter puts the buffer on the data pin most significant bit first. Bit 7 is presented as soon as transmission is enabled.
- R4: A receiver shifts the data pin into the buffer most significant bit first, so after 8 bits the buffer holds the byte that was sent.
- R5: With handshake off, data is sampled on rising clock-line edges and launched on falling edges. With handshake on, the two edges swap roles.
- R6: The done flag rises when a byte completes. A buffer write or a buffer read clears it, and it falls for no other reason.
- R7: With handshake on, a slave pulls the clock line low while it is busy: a receiving slave while its buffer is full (not yet read), and a transmitting slave while its buffer is empty (not yet written). It releases the line on the CPU access that ends the busy condition.
- R8: With handshake on, a master that has been started produces no clock pulse while the line is held low. It starts the byte once the line has been seen high again.
- R9: The data output enable is 0 whenever the channel is in receive mode, and also when a transmitter has no byte in progress (master idle, or slave with an empty buffer).
- R10: A start request that arrives while a master byte is in progress is ignored. The byte still has 8 pulses, and no further pulses follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the serial clock; 0: follow it |
| cfg_xmit | input | 1 | 1: transmit the buffer; 0: receive into it |
| cfg_hshk | input | 1 | 1: handshake mode with inverted clock polarity |
| cfg_div | input | DIV_W | Half-period of the master clock, minus one, in system clocks |
| start | input | 1 | Master only: one-cycle request to clock one byte |
| buf_wr | input | 1 | CPU buffer write strobe |
| buf_wdata | input | DATA_W | CPU write data |
| buf_rd | input | 1 | CPU buffer read strobe (clears full and done) |
| buf_rdata | output | DATA_W | Current buffer contents |
| done | output | 1 | Byte-complete flag |
| sd_in | input | 1 | Serial data pin, input side |
| sd_out | output | 1 | Serial data pin, output value |
| sd_oe | output | 1 | Serial data pin, output enable |
| sc_in | input | 1 | Clock line level, asynchronous |
| sc_pull_low | output | 1 | Open-drain pull-low enable for the clock line |

## Verification
The bench builds the default DATA_W=8, DIV_W=8 and SYNC_N=2, and it wires two copies of the block onto one shared open-drain clock line and one data wire. One copy is the master and the other is the slave, so every byte exercises the generated clock edges and the synchronised slave edges together, in both directions. Run-time dividers of 3 to 6 bring the tightest margin between the slave's two-stage synchroniser delay and the opposite clock edge within reach. The handshake cases make the slave really hold the line, which shows the master stalling and then recovering.

// File: rtl/sser_pkg.sv
package sser_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_WAIT,
        GEN_LOW,
        GEN_HIGH
    } gen_st_e;

endpackage

// File: rtl/sser_sync.sv
module sser_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC_N-1:0] pipe;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[SYNC_N-2:0], pin_i};
        s_d.last = s_q.pipe[SYNC_N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.pipe[SYNC_N-1];
    assign rise_o  = s_q.pipe[SYNC_N-1] & ~s_q.last;
    assign fall_o  = ~s_q.pipe[SYNC_N-1] & s_q.last;

endmodule

// File: rtl/sser_clkgen.sv
module sser_clkgen
    import sser_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int NBITS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hshk_i,
    input  logic             line_hi_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pull_low_o,
    output logic             fall_ev_o,
    output logic             rise_ev_o,
    output logic             busy_o,
    output logic             end_o
);

    typedef struct packed {
        gen_st_e          st;
        logic [DIV_W-1:0] cnt;
        logic [CNT_W-1:0] npulse;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d       = g_q;
        fall_ev_o = 1'b0;
        rise_ev_o = 1'b0;
        end_o     = 1'b0;
        case (g_q.st)
            GEN_IDLE: begin
                if (start_i) begin
                    g_d.st = GEN_WAIT;
                end
            end
            GEN_WAIT: begin
                if (!hshk_i || line_hi_i) begin
                    g_d.st     = GEN_LOW;
                    g_d.cnt    = '0;
                    g_d.npulse = '0;
                    fall_ev_o  = 1'b1;
                end
            end
            GEN_LOW: begin
                if (g_q.cnt == div_i) begin
                    g_d.st    = GEN_HIGH;
                    g_d.cnt   = '0;
                    rise_ev_o = 1'b1;
                end else begin
                    g_d.cnt = g_q.cnt + 1'b1;
                end
            end
            GEN_HIGH: begin
                if (g_q.cnt == div_i) begin
                    g_d.cnt = '0;
                    if (g_q.npulse == CNT_W'(NBITS - 1)) begin
                        g_d.st = GEN_IDLE;
                        end_o  = 1'b1;
                    end else begin
                        g_d.st     = GEN_LOW;
                        g_d.npulse = g_q.npulse + 1'b1;
                        fall_ev_o  = 1'b1;
                    end
                end else begin
                    g_d.cnt = g_q.cnt + 1'b1;
                end
            end
            default: g_d.st = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{st: GEN_IDLE, cnt: '0, npulse: '0};
        end else begin
            g_q <= g_d;
        end
    end

    assign pull_low_o = (g_q.st == GEN_LOW);
    assign busy_o     = (g_q.st != GEN_IDLE);

endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_ev_i,
    input  logic              launch_ev_i,
    input  logic              use_ext_i,
    input  logic              ext_end_i,
    input  logic              xmit_i,
    input  logic              sd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              done_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bufr;
        logic [CNT_W-1:0]  bitcnt;
        logic              armed;
        logic              full;
        logic              empty;
        logic              done;
    } shf_t;

    shf_t s_d, s_q;
    logic fin;

    always_comb begin
        s_d = s_q;
        fin = 1'b0;
        if (sample_ev_i) begin
            if (!xmit_i) begin
                s_d.bufr = {s_q.bufr[DATA_W-2:0], sd_i};
            end
            s_d.armed  = 1'b1;
            s_d.bitcnt = s_q.bitcnt + 1'b1;
            fin        = !use_ext_i && (s_q.bitcnt == CNT_W'(DATA_W - 1));
        end else if (launch_ev_i && s_q.armed) begin
            if (xmit_i) begin
                s_d.bufr = {s_q.bufr[DATA_W-2:0], 1'b0};
            end
            s_d.armed = 1'b0;
        end
        if (use_ext_i && ext_end_i) begin
            fin = 1'b1;
        end
        if (wr_i) begin
            s_d.bufr  = wdata_i;
            s_d.empty = 1'b0;
            s_d.done  = 1'b0;
        end
        if (rd_i) begin
            s_d.full = 1'b0;
            s_d.done = 1'b0;
        end
        if (fin) begin
            s_d.bitcnt = '0;
            s_d.armed  = 1'b0;
            s_d.done   = 1'b1;
            if (xmit_i) begin
                s_d.empty = 1'b1;
            end else begin
                s_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{bufr: '0, bitcnt: '0, armed: 1'b0, full: 1'b0, empty: 1'b1, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_o   = s_q.bufr;
    assign full_o  = s_q.full;
    assign empty_o = s_q.empty;
    assign done_o  = s_q.done;

endmodule

// File: rtl/sser_chan.sv
module sser_chan #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_xmit,
    input  logic              cfg_hshk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              start,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              done,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sc_in,
    output logic              sc_pull_low
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic line_hi, s_rise, s_fall;
    logic g_pull, g_fall, g_rise, g_busy, g_end;
    logic sample_ev, launch_ev;
    logic full, empty;
    logic [DATA_W-1:0] bufv;

    sser_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (sc_in),
        .level_o (line_hi),
        .rise_o  (s_rise),
        .fall_o  (s_fall)
    );

    sser_clkgen #(.DIV_W(DIV_W), .NBITS(DATA_W), .CNT_W(CNT_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cfg_master & start),
        .hshk_i     (cfg_hshk),
        .line_hi_i  (line_hi),
        .div_i      (cfg_div),
        .pull_low_o (g_pull),
        .fall_ev_o  (g_fall),
        .rise_ev_o  (g_rise),
        .busy_o     (g_busy),
        .end_o      (g_end)
    );

    // Edge roles: sample on rise and launch on fall normally, swapped in handshake mode.
    always_comb begin
        if (cfg_master) begin
            sample_ev = cfg_hshk ? g_fall : g_rise;
            launch_ev = cfg_hshk ? g_rise : g_fall;
        end else begin
            sample_ev = cfg_hshk ? s_fall : s_rise;
            launch_ev = cfg_hshk ? s_rise : s_fall;
        end
    end

    sser_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_ev_i (sample_ev),
        .launch_ev_i (launch_ev),
        .use_ext_i   (cfg_master),
        .ext_end_i   (g_end),
        .xmit_i      (cfg_xmit),
        .sd_i        (sd_in),
        .wr_i        (buf_wr),
        .wdata_i     (buf_wdata),
        .rd_i        (buf_rd),
        .buf_o       (bufv),
        .full_o      (full),
        .empty_o     (empty),
        .done_o      (done)
    );

    assign sc_pull_low = cfg_master ? g_pull
                                    : (cfg_hshk & (cfg_xmit ? empty : full));
    assign sd_oe       = cfg_xmit & (cfg_master ? g_busy : ~empty);
    assign sd_out      = sd_oe & bufv[DATA_W-1];
    assign buf_rdata   = bufv;

endmodule

// File: rtl/sser_chan_chk.sv
module sser_chan_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             cfg_xmit,
    input logic             cfg_hshk,
    input logic [DIV_W-1:0] cfg_div,
    input logic             buf_wr,
    input logic             buf_rd,
    input logic             done,
    input logic             sd_out,
    input logic             sd_oe,
    input logic             sc_pull_low
);

    logic [DIV_W:0] lowcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowcnt <= '0;
        end else if (sc_pull_low) begin
            lowcnt <= lowcnt + 1'b1;
        end else begin
            lowcnt <= '0;
        end
    end

    assert_rx_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_xmit |-> !sd_oe);

    assert_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $fell(sc_pull_low)) |-> (lowcnt == ({1'b0, cfg_div} + 1'b1)));

    assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(buf_rd || buf_wr));

    assert_slave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hshk && !cfg_master && !cfg_xmit && done) |-> sc_pull_low);

    assert_launch_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && cfg_xmit && sd_oe && $past(sd_oe) && (sd_out != $past(sd_out)))
            |-> (cfg_hshk ? $fell(sc_pull_low) : $rose(sc_pull_low)));

endmodule

bind sser_chan sser_chan_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_master  (cfg_master),
    .cfg_xmit    (cfg_xmit),
    .cfg_hshk    (cfg_hshk),
    .cfg_div     (cfg_div),
    .buf_wr      (buf_wr),
    .buf_rd      (buf_rd),
    .done        (done),
    .sd_out      (sd_out),
    .sd_oe       (sd_oe),
    .sc_pull_low (sc_pull_low)
);

// File: tb/sser_chan_bench.sv
module sser_chan_bench;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    logic       hshk = 1'b0;
    logic [7:0] div = 8'd3;
    logic       m_xmit = 1'b1, s_xmit = 1'b0;
    logic       m_start = 1'b0;
    logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic [7:0] m_wdata = '0, s_wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic       m_done, s_done, m_out, s_out, m_oe, s_oe, m_pull, s_pull;
    wire        line   = ~(m_pull | s_pull);
    wire        sd_bus = m_oe ? m_out : (s_oe ? s_out : 1'b1);

    sser_chan u_sser_chan (
        .clk(clk), .rst_n(rst_n), .cfg_master(1'b1), .cfg_xmit(m_xmit), .cfg_hshk(hshk),
        .cfg_div(div), .start(m_start), .buf_wr(m_wr), .buf_wdata(m_wdata), .buf_rd(m_rd),
        .buf_rdata(m_rdata), .done(m_done), .sd_in(sd_bus), .sd_out(m_out), .sd_oe(m_oe),
        .sc_in(line), .sc_pull_low(m_pull)
    );

    sser_chan u_peer (
        .clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_xmit(s_xmit), .cfg_hshk(hshk),
        .cfg_div(div), .start(1'b0), .buf_wr(s_wr), .buf_wdata(s_wdata), .buf_rd(s_rd),
        .buf_rdata(s_rdata), .done(s_done), .sd_in(sd_bus), .sd_out(s_out), .sd_oe(s_oe),
        .sc_in(line), .sc_pull_low(s_pull)
    );

    int n_chk = 0, n_bad = 0;

    // Bus monitor: counts falling edges and captures data at the expected sampling edge.
    int   falls = 0, samps = 0;
    logic line_prev = 1'b1;
    logic [7:0] mon = '0;
    always @(negedge clk) begin
        if (line != line_prev) begin
            if (!line) falls = falls + 1;
            if (line != hshk) begin
                mon   = {mon[6:0], sd_bus};
                samps = samps + 1;
            end
        end
        line_prev = line;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_write(input logic [7:0] d);
        m_wdata = d; m_wr = 1'b1; cyc(1); m_wr = 1'b0;
    endtask
    task automatic s_write(input logic [7:0] d);
        s_wdata = d; s_wr = 1'b1; cyc(1); s_wr = 1'b0;
    endtask
    task automatic rd_both();
        m_rd = 1'b1; s_rd = 1'b1; cyc(1); m_rd = 1'b0; s_rd = 1'b0;
    endtask
    task automatic kick();
        m_start = 1'b1; cyc(1); m_start = 1'b0;
    endtask
    task automatic wait_mdone();
        for (int i = 0; i < 3000 && !m_done; i++) cyc(1);
        chk(m_done, 1, "R6 master done set");
    endtask

    function automatic logic [7:0] sent_byte(input bit mtx, input logic [7:0] dm,
                                             input logic [7:0] ds);
        return mtx ? dm : ds;
    endfunction

    task automatic run_xfer(input bit hs, input bit mtx, input logic [7:0] dm,
                            input logic [7:0] ds, input logic [7:0] dv, input bit restart);
        int f0, n0;
        logic [7:0] exp;
        hshk = hs; div = dv; cyc(4);
        if (mtx) begin
            m_xmit = 1'b1; m_write(dm);
        end else begin
            s_write(ds); s_xmit = 1'b1; m_xmit = 1'b0;
        end
        cyc(4);
        f0 = falls; n0 = samps;
        kick();
        if (restart) begin
            cyc(20); kick();
        end
        wait_mdone();
        cyc(12);
        exp = sent_byte(mtx, dm, ds);
        chk(mtx ? s_rdata : m_rdata, exp, "R4 received byte");
        chk(mon, exp, "R3 R5 bus bits at sampling edge");
        chk(samps - n0, 8, "R5 sampling edges");
        chk(falls - f0, 8, "R2 pulse count");
        chk(m_pull, 0, "R2 master released");
        chk(s_done, 1, "R6 slave done set");
        chk(m_oe, 0, "R9 master idle float");
        chk(s_oe, 0, "R9 slave float");
        if (hs) chk(s_pull, 1, "R7 busy slave holds line");
        if (restart) begin
            cyc(60);
            chk(falls - f0, 8, "R10 restart ignored");
        end
        rd_both();
        chk(m_done, 0, "R6 done cleared by read");
        s_xmit = 1'b0;
        cyc(8);
    endtask

    initial begin : main
        void'($urandom(32'd1957));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk(m_done, 0, "R1 done");
        chk(m_rdata, 0, "R1 buffer");
        chk(m_oe, 0, "R1 output enable");
        chk(m_pull, 0, "R1 clock release");

        // Directed: both polarities, both directions, extreme bytes.
        run_xfer(1'b0, 1'b1, 8'h80, 8'h00, 8'd3, 1'b0);
        run_xfer(1'b0, 1'b0, 8'h00, 8'h01, 8'd3, 1'b0);
        run_xfer(1'b1, 1'b1, 8'hA5, 8'h00, 8'd3, 1'b0);
        run_xfer(1'b1, 1'b0, 8'h00, 8'h5A, 8'd6, 1'b0);

        for (int k = 0; k < 24; k++) begin
            run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     8'($urandom), 8'($urandom), 8'($urandom_range(3, 6)), 1'b0);
        end

        // R10: second start mid-byte, both polarities.
        run_xfer(1'b0, 1'b1, 8'hC3, 8'h00, 8'd4, 1'b1);
        run_xfer(1'b1, 1'b1, 8'h3C, 8'h00, 8'd4, 1'b1);

        // R7 / R8: full receiving slave stalls the master.
        begin
            int f0;
            hshk = 1'b1; m_xmit = 1'b1; div = 8'd4; cyc(4);
            m_write(8'h96); kick(); wait_mdone(); cyc(12);
            chk(s_pull, 1, "R7 full slave holds line");
            chk(line, 0, "R7 line low");
            m_write(8'h4B);
            chk(m_done, 0, "R6 done cleared by write");
            f0 = falls;
            kick(); cyc(80);
            chk(falls - f0, 0, "R8 no pulses while held");
            chk(m_done, 0, "R8 master stalled");
            chk(s_rdata, 8'h96, "R8 held byte intact");
            s_rd = 1'b1; cyc(1); s_rd = 1'b0;
            chk(s_pull, 0, "R7 release on read");
            wait_mdone(); cyc(12);
            chk(s_rdata, 8'h4B, "R8 byte after release");
            chk(falls - f0, 8, "R8 pulse count after release");
            rd_both(); cyc(8);
        end

        // R7: transmitting slave with empty buffer holds the line.
        hshk = 1'b1; s_xmit = 1'b1; cyc(8);
        chk(s_pull, 1, "R7 empty slave holds line");
        chk(s_oe, 0, "R9 empty slave float");
        s_write(8'h11); cyc(2);
        chk(s_pull, 0, "R7 release on write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule